// File: doc/BRIEF.md
# Masked Polled Alarm Comparator

The block holds seven alarm threshold bytes and one field-enable byte, and compares them with the live calendar fields that the timekeeping counters supply: seconds, minutes, hours, date of month, month, day of week and year. A field takes part in the comparison only when its enable bit is set. Each full byte is compared. The comparison happens in a cycle where the counters signal that they have just advanced one second. If every enabled field then equals its threshold, a sticky alarm flag is set.

Software polls the flag as the top bit of the Minutes register. The block supplies that register's read value by merging the flag with the live minutes field. Any read or write of the enable byte or of a threshold byte acknowledges the alarm and clears the flag. The block sits on a simple single-cycle register bus. It uses a 5-bit register index, and read data are combinational from the index.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset the enable register reads 00h. The thresholds read, from seconds to year: 7Fh, 7Fh, BFh, 3Fh, 1Fh, 07h, FFh. The alarm flag is 0.
- R2: The enable register is at index 10. Its bits 6:0 are stored and bit 7 always reads 0. The thresholds are at indices 12 to 18, in the order seconds, minutes, hours, date, month, day of week, year. A write to one of these indices is read back unchanged on a later read.
- R3: Enable bit i selects field i, in the order bit 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. A field whose bit is clear has no effect on the result.
- R4: The flag becomes 1 on the clock edge that ends a `tick_done` cycle in which every enabled threshold equals its live field in all 8 bits.
- R5: With an enable value of 00h the flag never sets.
- R6: A match in a cycle without `tick_done` does not set the flag.
- R7: Once set, the flag stays 1 through later ticks that do not match.
- R8: A bus read or write at index 10 or 12 to 18 clears the flag on that cycle's edge. Accesses at any other index leave the flag unchanged.
- R9: When a clearing access and a setting match fall in the same cycle, the flag ends at 0.
- R10: Index 1 reads as {flag, live minutes bits 6:0}. Any index the block does not own reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_done | input | 1 | One-cycle pulse: the counters have just advanced one second |
| live_time | input | 56 | Live fields, seconds in bits 7:0 up to year in bits 55:48 |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the index |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
Writes, the flag set and the flag clear each appear one edge after the cycle that carries the stimulus. Read data appear within that same cycle. The bench drives every input on the falling edge. It samples read data shortly after that falling edge, while the access is still held. It samples the flag and the stored registers at the next falling edge, once the single register stage has updated. The same-cycle collision in R9 and the no-tick match in R6 are driven as single-cycle events. Each is checked at the following falling edge.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int FLD_W    = 8;
  localparam int FLD_N    = 7;
  localparam int IDX_W    = 5;
  localparam int IDX_MIN  = 1;
  localparam int IDX_CFG  = 10;
  localparam int IDX_THR0 = 12;

  // power-on value of threshold slot i (seconds first)
  function automatic logic [FLD_W-1:0] thr_por(input int i);
    case (i)
      0: return 8'h7F;
      1: return 8'h7F;
      2: return 8'hBF;
      3: return 8'h3F;
      4: return 8'h1F;
      5: return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  // a field passes when it is not selected or equals its threshold
  function automatic logic field_ok(input logic sel,
                                    input logic [FLD_W-1:0] thr,
                                    input logic [FLD_W-1:0] live);
    return !sel || (thr == live);
  endfunction
endpackage

// File: rtl/alarm_thr_bank.sv
module alarm_thr_bank
  import alarm_pkg::*;
#(
  parameter int DW = FLD_W,
  parameter int NF = FLD_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cfg,
  input  logic [NF-1:0]   wr_thr,
  input  logic [DW-1:0]   wdata,
  output logic [NF-1:0]   cfg_q,
  output logic [NF*DW-1:0] thr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= wdata[NF-1:0];
  end

  for (genvar i = 0; i < NF; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thr_q[i*DW +: DW] <= DW'(thr_por(i));
      else if (wr_thr[i]) thr_q[i*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter int DW = FLD_W,
  parameter int NF = FLD_N
) (
  input  logic [NF-1:0]    cfg,
  input  logic [NF*DW-1:0] thr,
  input  logic [NF*DW-1:0] live,
  input  logic             tick,
  output logic [NF-1:0]    ok_vec,
  output logic             fire
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign ok_vec[i] = field_ok(cfg[i], thr[i*DW +: DW], live[i*DW +: DW]);
  end

  assign fire = tick && (|cfg) && (&ok_vec);
endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int DW       = FLD_W,
  parameter int NF       = FLD_N,
  parameter int AW       = IDX_W,
  parameter int MIN_IDX  = IDX_MIN,
  parameter int CFG_IDX  = IDX_CFG,
  parameter int THR_BASE = IDX_THR0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_done,
  input  logic [NF*DW-1:0] live_time,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             alarm_flag
);
  localparam int PAD = DW - NF;

  logic             cfg_hit;
  logic [NF-1:0]    thr_hit;
  logic             min_hit;
  logic             clr_evt;
  logic             fire_evt;
  logic [NF-1:0]    ok_vec;
  logic [NF-1:0]    cfg_q;
  logic [NF*DW-1:0] thr_q;

  assign cfg_hit = (bus_addr == AW'(CFG_IDX));
  assign min_hit = (bus_addr == AW'(MIN_IDX));
  for (genvar i = 0; i < NF; i++) begin : g_dec
    assign thr_hit[i] = (bus_addr == AW'(THR_BASE + i));
  end

  assign clr_evt = bus_en && (cfg_hit || (|thr_hit));

  alarm_thr_bank #(.DW(DW), .NF(NF)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_cfg (bus_en && bus_wr && cfg_hit),
    .wr_thr ({NF{bus_en && bus_wr}} & thr_hit),
    .wdata  (bus_wdata),
    .cfg_q  (cfg_q),
    .thr_q  (thr_q)
  );

  alarm_cmp #(.DW(DW), .NF(NF)) u_cmp (
    .cfg    (cfg_q),
    .thr    (thr_q),
    .live   (live_time),
    .tick   (tick_done),
    .ok_vec (ok_vec),
    .fire   (fire_evt)
  );

  alarm_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_evt),
    .set   (fire_evt),
    .flag  (alarm_flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (cfg_hit) bus_rdata = {{PAD{1'b0}}, cfg_q};
    if (min_hit) bus_rdata = {alarm_flag, live_time[DW +: DW-1]};
    for (int i = 0; i < NF; i++) begin
      if (thr_hit[i]) bus_rdata = thr_q[i*DW +: DW];
    end
  end
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int NF = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_done,
  input logic          clr_evt,
  input logic          fire_evt,
  input logic [NF-1:0] cfg_q,
  input logic          alarm_flag
);
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_evt && !clr_evt) |=> alarm_flag);

  assert_no_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == '0) |-> !fire_evt);

  assert_tick_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick_done));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_evt) |=> alarm_flag);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !alarm_flag);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && fire_evt) |=> !alarm_flag);
endmodule

bind alarm_match_unit alarm_match_chk #(.NF(NF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_done  (tick_done),
  .clr_evt    (clr_evt),
  .fire_evt   (fire_evt),
  .cfg_q      (cfg_q),
  .alarm_flag (alarm_flag)
);

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_MIN = 1, IDX_CFG = 10, IDX_THR0 = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_done = 1'b0;
  logic [55:0] live_time = '0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        alarm_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_unit u0 (
    .clk(clk), .rst_n(rst_n), .tick_done(tick_done), .live_time(live_time),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_flag(alarm_flag)
  );

  // vector: {cfg, live sec, live min, live hour, expected flag}
  localparam logic [32:0] VEC [10] = '{
    {8'h03, 8'h30, 8'h15, 8'h00, 1'b1},
    {8'h03, 8'h31, 8'h15, 8'h08, 1'b0},
    {8'h07, 8'h30, 8'h15, 8'h08, 1'b1},
    {8'h07, 8'h30, 8'h15, 8'h09, 1'b0},
    {8'h00, 8'h30, 8'h15, 8'h08, 1'b0},
    {8'h40, 8'h30, 8'h15, 8'h08, 1'b0},
    {8'h38, 8'h11, 8'h22, 8'h33, 1'b1},
    {8'h7F, 8'h30, 8'h15, 8'h08, 1'b0},
    {8'h01, 8'h30, 8'h59, 8'h23, 1'b1},
    {8'h04, 8'h00, 8'h00, 8'h08, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // live fields: date 04, month 07, day 05 match the thresholds; year 03 does not
  task automatic set_live(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    live_time = {8'h03, 8'h05, 8'h07, 8'h04, h, m, s};
  endtask

  task automatic bus_write(input int idx, input logic [7:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 5'(idx); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int idx, output logic [7:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 5'(idx);
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic pulse_tick();
    tick_done = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_done = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] por [7] = '{8'h7F, 8'h7F, 8'hBF, 8'h3F, 8'h1F, 8'h07, 8'hFF};
    logic [7:0] thv [7] = '{8'h30, 8'h15, 8'h08, 8'h04, 8'h07, 8'h05, 8'h02};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 flag", {7'd0, alarm_flag}, 8'h00);
    bus_read(IDX_CFG, rd); check("R1 cfg", rd, 8'h00);
    for (int i = 0; i < 7; i++) begin
      bus_read(IDX_THR0 + i, rd); check("R1 thr", rd, por[i]);
    end

    // R2 map and readback
    bus_write(IDX_CFG, 8'hFF);
    bus_read(IDX_CFG, rd); check("R2 cfg bit7 zero", rd, 8'h7F);
    for (int i = 0; i < 7; i++) bus_write(IDX_THR0 + i, thv[i]);
    for (int i = 0; i < 7; i++) begin
      bus_read(IDX_THR0 + i, rd); check("R2 thr readback", rd, thv[i]);
    end

    // R3 R4 R5 table of enable patterns
    for (int v = 0; v < 10; v++) begin
      bus_write(IDX_CFG, VEC[v][32:25]);
      set_live(VEC[v][24:17], VEC[v][16:9], VEC[v][8:1]);
      pulse_tick();
      check("R3/R4/R5 vector", {7'd0, alarm_flag}, {7'd0, VEC[v][0]});
    end

    // R6 match without tick
    bus_write(IDX_CFG, 8'h01);
    set_live(8'h30, 8'h15, 8'h08);
    @(posedge clk); @(negedge clk);
    check("R6 no tick", {7'd0, alarm_flag}, 8'h00);

    // R4 all 8 bits compared
    bus_write(IDX_CFG, 8'h04);
    set_live(8'h30, 8'h15, 8'h88);
    pulse_tick();
    check("R4 full byte", {7'd0, alarm_flag}, 8'h00);

    // R7 sticky
    bus_write(IDX_CFG, 8'h01);
    set_live(8'h30, 8'h15, 8'h08);
    pulse_tick();
    check("R7 set", {7'd0, alarm_flag}, 8'h01);
    set_live(8'h31, 8'h15, 8'h08);
    pulse_tick();
    check("R7 held", {7'd0, alarm_flag}, 8'h01);

    // R10 minutes view, R8 non-clearing accesses
    bus_read(IDX_MIN, rd); check("R10 minutes with flag", rd, 8'h95);
    check("R8 minutes read keeps flag", {7'd0, alarm_flag}, 8'h01);
    bus_read(0, rd); check("R10 unowned reads zero", rd, 8'h00);
    bus_write(0, 8'hAA);
    check("R8 other index keeps flag", {7'd0, alarm_flag}, 8'h01);

    // R8 threshold read clears
    bus_read(IDX_THR0 + 1, rd);
    check("R8 thr read clears", {7'd0, alarm_flag}, 8'h00);

    // R8 threshold write clears
    set_live(8'h30, 8'h15, 8'h08);
    pulse_tick();
    check("R8 rearm", {7'd0, alarm_flag}, 8'h01);
    bus_write(IDX_THR0 + 1, 8'h15);
    check("R8 thr write clears", {7'd0, alarm_flag}, 8'h00);

    // R9 clear beats simultaneous match
    pulse_tick();
    check("R9 rearm", {7'd0, alarm_flag}, 8'h01);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 5'(IDX_CFG); tick_done = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; tick_done = 1'b0;
    check("R9 clear wins", {7'd0, alarm_flag}, 8'h00);
    bus_read(IDX_MIN, rd); check("R10 minutes without flag", rd, 8'h15);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule